// File: doc/BRIEF.md
# Keyboard Wake Interrupt Controller

The controller monitors a parameterized group of keypad inputs. It raises a status flag when a key event occurs. Each pin has its own enable and its own polarity bit, and the polarity bit selects which level counts as "pressed".

Every input is resynchronized by two flops. The synchronized value is then compared against its previous sample. An event qualifies only when one or more enabled pins go from released to pressed while every other enabled pin is released and stays released.

A mode input picks one of two detection styles:
- **Edge-only:** the flag is set by qualifying edges alone.
- **Edge-and-level:** the flag is also forced on for as long as any enabled pin is pressed.

Software clears the flag with a write-one acknowledge strobe. The strobe is a pulse input and carries no stored state, so the acknowledge field reads back as zero. The interrupt request follows the flag, gated by an interrupt enable.

When the stop input is high, edge detection is suspended. In that state any enabled pressed pin drives the wake output directly through combinational logic, with no clock needed.

Top module: `kbd_wake_ctrl`

## Requirements
- R1: A press reaches the flag on the third rising clock edge after the input changes: two edges pass through the synchronizer, and the flag registers on the third.
- R2: In edge-only mode, a single enabled pin going from released to pressed, with all other enabled pins released, sets the flag.
- R3: A press is not counted when any other enabled pin is already pressed.
- R4: A pin with enable 0 never sets the flag, and it is left out of the all-others-released check.
- R5: Polarity bit 1 means the pressed level is high; polarity bit 0 means the pressed level is low.
- R6: With mode 1, the flag stays set in every cycle in which any enabled synchronized pin is pressed, and an acknowledge has no effect then; once all pins are released, an acknowledge clears it.
- R7: With mode 0, an acknowledge strobe clears the flag on the next clock edge even while a pin is still held pressed.
- R8: When a qualifying edge and an acknowledge fall on the same clock edge, the flag ends up set.
- R9: The interrupt request equals the flag ANDed with the interrupt enable, with no added delay.
- R10: With stop high, the wake output is the combinational OR of the enabled pressed raw inputs, and edges do not set the flag. With stop low, wake is 0.
- R11: After reset the flag, interrupt request and wake are 0. Idle inputs of either polarity cause no false event, even in mode 1.
- R12: Changing a pin's enable or polarity while that pin is pressed does not produce an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_in | input | NUM_KEYS | Raw keypad pins |
| pin_en | input | NUM_KEYS | Per-pin participation enable |
| pin_pol | input | NUM_KEYS | Per-pin pressed level (1 = high) |
| lvl_mode | input | 1 | 0 = edge-only, 1 = edge-and-level |
| irq_en | input | 1 | Interrupt enable |
| ack_wr | input | 1 | Write-one acknowledge strobe |
| stop_mode | input | 1 | Stop state: asynchronous level wake |
| flag | output | 1 | Key event status flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Asynchronous wake request |

## Verification
A corrupted previous-sample register shows up as a flag that rises without a press, or stays low after one, three clock edges after the pin change. The bench samples at exactly that point.

A wrong flag state appears on `irq` in the same cycle whenever the interrupt is enabled. An acknowledge that fails to clear the flag is visible one edge after the strobe.

The stop path is combinational, so a fault there shows on `wake` within the same time step as the pin change.

// File: rtl/kbd_wake_pkg.sv
// Shared helpers for the keyboard wake controller.
// Assumes: polarity bit 1 means a pin is pressed when high.
package kbd_wake_pkg;

    // Returns 1 when a raw pin level matches its pressed level.
    function automatic logic is_pressed(input logic raw, input logic pol);
        return ~(raw ^ pol);
    endfunction

endpackage

// File: rtl/kbd_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes: rst_val is the released level of each pin, so that reset
// leaves every pin reading as released.
module kbd_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1;

    // Two-stage capture of the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= rst_val;
            dout   <= rst_val;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/kbd_edge_qual.sv
// Normalizes synchronized pins to "pressed" and detects qualifying edges.
// An edge qualifies when one or more enabled pins rise and every other
// enabled pin was released and still is. A pin whose enable or polarity
// changed in this cycle cannot rise. Edges are suppressed in stop mode.
module kbd_edge_qual
    import kbd_wake_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    input  logic [WIDTH-1:0] pin_en,
    input  logic [WIDTH-1:0] pin_pol,
    input  logic             stop_mode,
    output logic             qual_edge,
    output logic             any_act
);
    logic [WIDTH-1:0] act;
    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] pol_q;
    logic [WIDTH-1:0] cfg_chg;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] busy;

    // Per-pin pressed level, masked by the pin's enable.
    for (genvar i = 0; i < WIDTH; i++) begin : g_norm
        assign act[i] = is_pressed(sync_in[i], pin_pol[i]) & pin_en[i];
    end

    // Rise detection and the all-others-released qualification.
    always_comb begin
        cfg_chg   = (pin_en ^ en_q) | (pin_pol ^ pol_q);
        rise      = act & ~prev & ~cfg_chg;
        busy      = (act | (prev & pin_en)) & ~rise;
        qual_edge = (|rise) && (busy == '0) && !stop_mode;
        any_act   = |act;
    end

    // Previous sample and the configuration history used for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev  <= '0;
            en_q  <= pin_en;
            pol_q <= pin_pol;
        end else begin
            prev  <= act;
            en_q  <= pin_en;
            pol_q <= pin_pol;
        end
    end

    // R11: the previous sample leaves reset at the released level.
    a_r11_prev_released: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (prev == '0));
endmodule

// File: rtl/kbd_flag.sv
// Status flag: set by qualifying edges, or held by pressed pins in level
// mode; cleared by the write-one acknowledge unless a set or hold applies.
module kbd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_edge,
    input  logic any_act,
    input  logic lvl_mode,
    input  logic ack_wr,
    output logic flag
);
    logic hold;
    logic set_now;
    logic clr_now;

    // Set, hold and clear terms; set has priority over clear.
    always_comb begin
        hold    = lvl_mode & any_act;
        set_now = qual_edge | hold;
        clr_now = ack_wr & ~hold;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_now) flag <= 1'b1;
        else if (clr_now) flag <= 1'b0;
    end

    // R2 and R8: a qualifying edge always leaves the flag set.
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        qual_edge |=> flag);
    // R6: in level mode, a pressed pin keeps the flag set.
    a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode && any_act) |=> flag);
    // R7: in edge-only mode, an acknowledge without a new edge clears the flag.
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !lvl_mode && !qual_edge) |=> !flag);
    // R11: the flag never rises without a cause.
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(qual_edge || (lvl_mode && any_act)));
endmodule

// File: rtl/kbd_wake_ctrl.sv
// Keyboard wake interrupt controller top.
// Assumes: pins are asynchronous to clk; ack_wr is a single-cycle strobe;
// the wake path is combinational so it works with clocks stopped.
module kbd_wake_ctrl
    import kbd_wake_pkg::*;
#(
    parameter int NUM_KEYS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_in,
    input  logic [NUM_KEYS-1:0] pin_en,
    input  logic [NUM_KEYS-1:0] pin_pol,
    input  logic                lvl_mode,
    input  logic                irq_en,
    input  logic                ack_wr,
    input  logic                stop_mode,
    output logic                flag,
    output logic                irq,
    output logic                wake
);
    logic [NUM_KEYS-1:0] key_sync;
    logic [NUM_KEYS-1:0] raw_act;
    logic                qual_edge;
    logic                any_act;

    kbd_sync #(.WIDTH(NUM_KEYS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rst_val(~pin_pol),
        .din    (key_in),
        .dout   (key_sync)
    );

    kbd_edge_qual #(.WIDTH(NUM_KEYS)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (key_sync),
        .pin_en   (pin_en),
        .pin_pol  (pin_pol),
        .stop_mode(stop_mode),
        .qual_edge(qual_edge),
        .any_act  (any_act)
    );

    kbd_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual_edge(qual_edge),
        .any_act  (any_act),
        .lvl_mode (lvl_mode),
        .ack_wr   (ack_wr),
        .flag     (flag)
    );

    // Unsynchronized pressed levels used only by the stop-mode wake path.
    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_raw
        assign raw_act[i] = is_pressed(key_in[i], pin_pol[i]) & pin_en[i];
    end

    // Interrupt request and asynchronous wake.
    always_comb begin
        irq  = flag & irq_en;
        wake = stop_mode & (|raw_act);
    end
endmodule

// File: tb/kbd_wake_ctrl_bench.sv
`timescale 1ns/1ps
module kbd_wake_ctrl_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] key = 8'h80;
    logic [N-1:0] en = 8'hFF;
    logic [N-1:0] pol = 8'h7F;
    logic         lvl = 1'b0;
    logic         ie = 1'b1;
    logic         ack = 1'b0;
    logic         stop = 1'b0;
    logic         flag, irq, wake;
    int           checks = 0;
    int           fails = 0;

    always #2.5 clk = ~clk;

    kbd_wake_ctrl #(.NUM_KEYS(N)) u_kbd_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .key_in(key), .pin_en(en), .pin_pol(pol),
        .lvl_mode(lvl), .irq_en(ie), .ack_wr(ack), .stop_mode(stop),
        .flag(flag), .irq(irq), .wake(wake)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        lvl = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(5);
        check("R11 flag after reset", flag, 1'b0);
        check("R11 irq after reset", irq, 1'b0);
        check("R11 wake after reset", wake, 1'b0);
        lvl = 1'b0;
    endtask

    task automatic t_latency();
        key[0] = 1'b1;
        tick(2);
        check("R1 flag low after two edges", flag, 1'b0);
        tick(1);
        check("R1 R2 flag set on third edge", flag, 1'b1);
        check("R9 irq follows flag", irq, 1'b1);
        key[0] = 1'b0;
        tick(3);
        pulse_ack();
        check("R7 ack clears flag", flag, 1'b0);
    endtask

    task automatic t_irq_mask();
        ie = 1'b0;
        key[0] = 1'b1;
        tick(3);
        check("R9 flag set with irq disabled", flag, 1'b1);
        check("R9 irq masked", irq, 1'b0);
        ie = 1'b1;
        #1;
        check("R9 irq on enable", irq, 1'b1);
        key[0] = 1'b0;
        tick(3);
        pulse_ack();
    endtask

    task automatic t_polarity();
        key[7] = 1'b0;
        tick(3);
        check("R5 active-low press sets flag", flag, 1'b1);
        key[7] = 1'b1;
        tick(3);
        pulse_ack();
        check("R5 flag cleared after release", flag, 1'b0);
    endtask

    task automatic t_others();
        key[1] = 1'b1;
        tick(3);
        check("R2 pin1 press", flag, 1'b1);
        pulse_ack();
        check("R7 ack clears while held", flag, 1'b0);
        key[2] = 1'b1;
        tick(4);
        check("R3 press ignored while other held", flag, 1'b0);
        key[1] = 1'b0;
        key[2] = 1'b0;
        tick(3);
        check("R3 release sets nothing", flag, 1'b0);
    endtask

    task automatic t_disabled();
        en[3] = 1'b0;
        tick(1);
        key[3] = 1'b1;
        tick(4);
        check("R4 disabled pin does not set", flag, 1'b0);
        key[4] = 1'b1;
        tick(3);
        check("R4 disabled held pin not busy", flag, 1'b1);
        key[3] = 1'b0;
        key[4] = 1'b0;
        tick(3);
        pulse_ack();
        en[3] = 1'b1;
        tick(2);
    endtask

    task automatic t_level();
        lvl = 1'b1;
        key[0] = 1'b1;
        tick(3);
        check("R6 level press sets", flag, 1'b1);
        pulse_ack();
        check("R6 ack ignored while held", flag, 1'b1);
        key[0] = 1'b0;
        tick(3);
        pulse_ack();
        check("R6 ack clears after release", flag, 1'b0);
        lvl = 1'b0;
    endtask

    task automatic t_setwins();
        key[5] = 1'b1;
        tick(2);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check("R8 set wins over ack", flag, 1'b1);
        key[5] = 1'b0;
        tick(3);
        pulse_ack();
    endtask

    task automatic t_stop();
        stop = 1'b1;
        key[5] = 1'b1;
        #1;
        check("R10 wake immediate in stop", wake, 1'b1);
        tick(4);
        check("R10 no edge flag in stop", flag, 1'b0);
        key[5] = 1'b0;
        #1;
        check("R10 wake drops on release", wake, 1'b0);
        tick(3);
        stop = 1'b0;
        key[5] = 1'b1;
        #1;
        check("R10 no wake outside stop", wake, 1'b0);
        tick(3);
        check("R10 edges resume after stop", flag, 1'b1);
        key[5] = 1'b0;
        tick(3);
        pulse_ack();
    endtask

    task automatic t_cfg();
        en[6] = 1'b0;
        tick(1);
        key[6] = 1'b1;
        tick(4);
        en[6] = 1'b1;
        tick(4);
        check("R12 enabling pressed pin no edge", flag, 1'b0);
        pol[6] = 1'b0;
        tick(3);
        pol[6] = 1'b1;
        tick(4);
        check("R12 polarity flip no edge", flag, 1'b0);
        key[6] = 1'b0;
        tick(3);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_irq_mask();
        t_polarity();
        t_others();
        t_disabled();
        t_level();
        t_setwins();
        t_stop();
        t_cfg();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule